// File: doc/BRIEF.md
# Relocatable Interrupt Vector Controller

This block picks one interrupt request to service out of a set of request lines and computes the program-memory fetch address of that request's vector. Line 0 is the reset request. Line 1 is the first external request. The remaining lines are peripheral sources. Each cycle, the lowest-numbered line that is enabled wins. One cycle later the block presents that line's vector address with a valid strobe, and a one-hot acknowledge on the same line. The requesting logic uses the acknowledge to clear its pending flag.

The vector table has two possible locations: program-memory address zero, or the base of a boot section supplied on `boot_base_i`. A table-select bit chooses between them. That bit is protected by a two-step sequence. First, a write with the unlock bit set opens a short window. Then a second write, made while the window is open, sets the new select value. A select write made at any other time is dropped.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, `vec_valid_o` is 0, `ack_o` is all zero and the table-select bit is clear, so vector addresses are based at 0.
- R2: When several enabled lines request in the same cycle, the lowest index wins. Line 0 (reset) beats all others, and line 1 (external request) beats every line above it.
- R3: Line 0 is serviced whatever the value of `gie_i`. Lines 1 and above are serviced only when `gie_i` is 1 in the cycle they are sampled.
- R4: A request sampled at a clock edge produces, right after that edge, `vec_valid_o`=1 and `vec_addr_o` = table base + 2 × winning index.
- R5: With the select bit clear, the table base is 0.
- R6: With the select bit set, the table base is `boot_base_i`.
- R7: A write with `cfg_wdata_i[1]`=1 (unlock) leaves the select bit unchanged and opens a window. The window covers the next four clock edges. A write at one of those edges with `cfg_wdata_i[1]`=0 loads the select bit from `cfg_wdata_i[0]` and closes the window.
- R8: A select write made with no window open is ignored. This includes a write at the fifth edge after the unlock write and a write with no unlock before it.
- R9: `ack_o` is one-hot on the winning line and is high exactly when `vec_valid_o` is high. Both are 0 in any cycle after a sample in which no enabled line requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_SRC | Pending request lines, bit 0 is reset |
| gie_i | input | 1 | Global enable for lines 1 and above |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_wdata_i | input | 2 | Bit 1 unlock, bit 0 table select |
| boot_base_i | input | ADDR_W | Boot section base address |
| vec_addr_o | output | ADDR_W | Vector fetch address |
| vec_valid_o | output | 1 | Vector address valid |
| ack_o | output | NUM_SRC | One-hot acknowledge of the winning line |

## Verification
The assertions assume that a requester drops its line in the cycle after it sees its acknowledge. The bench clears every request at the same negedge where it checks the result, so the same line is never serviced twice. The assertions also assume `boot_base_i` is even and stays stable while the select bit is set. The bench holds it at one even value for the whole run. It issues unlock and select writes only as single-cycle strobes, so the edge each write lands on is known exactly.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int unsigned CFG_W      = 2;
  localparam int unsigned CFG_SEL    = 0;  // table select
  localparam int unsigned CFG_UNLOCK = 1;  // change enable

  function automatic int unsigned idx_width(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
  parameter int unsigned NUM_SRC = 8,
  localparam int unsigned IDX_W  = irq_vec_pkg::idx_width(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] req_i,
  output logic [NUM_SRC-1:0] grant_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic               any_o
);
  logic [NUM_SRC-1:0] blocked;

  assign blocked[0] = 1'b0;
  assign grant_o[0] = req_i[0];
  for (genvar i = 1; i < NUM_SRC; i++) begin : g_chain
    assign blocked[i] = blocked[i-1] | req_i[i-1];
    assign grant_o[i] = req_i[i] & ~blocked[i];
  end

  assign any_o = |req_i;

  always_comb begin
    idx_o = '0;
    for (int unsigned i = 0; i < NUM_SRC; i++)
      if (grant_o[i]) idx_o = IDX_W'(i);
  end

  always_comb begin
    a_grant_onehot_r2: assert ($onehot0(grant_o));
  end
endmodule

// File: rtl/irq_vec_guard.sv
module irq_vec_guard
  import irq_vec_pkg::*;
#(
  parameter int unsigned GUARD_CYCLES = 4,
  localparam int unsigned CNT_W       = $clog2(GUARD_CYCLES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic             sel_o
);
  logic [CNT_W-1:0] win_cnt_q;
  logic             win_open;

  assign win_open = (win_cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_cnt_q <= '0;
      sel_o     <= 1'b0;
    end else if (we_i && wdata_i[CFG_UNLOCK]) begin
      win_cnt_q <= CNT_W'(GUARD_CYCLES);
    end else if (we_i && win_open) begin
      sel_o     <= wdata_i[CFG_SEL];
      win_cnt_q <= '0;
    end else if (win_open) begin
      win_cnt_q <= win_cnt_q - 1'b1;
    end
  end

  p_sel_guard_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sel_o) |-> $past(win_open && we_i && !wdata_i[CFG_UNLOCK]));

  p_win_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_cnt_q <= CNT_W'(GUARD_CYCLES));

  p_win_arm_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wdata_i[CFG_UNLOCK]) |=> (win_cnt_q == CNT_W'(GUARD_CYCLES)) && $stable(sel_o));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_vec_pkg::*;
#(
  parameter int unsigned NUM_SRC      = 8,
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned GUARD_CYCLES = 4,
  localparam int unsigned IDX_W       = idx_width(NUM_SRC)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_SRC-1:0]  req_i,
  input  logic                gie_i,
  input  logic                cfg_we_i,
  input  logic [1:0]          cfg_wdata_i,
  input  logic [ADDR_W-1:0]   boot_base_i,
  output logic [ADDR_W-1:0]   vec_addr_o,
  output logic                vec_valid_o,
  output logic [NUM_SRC-1:0]  ack_o
);
  logic [NUM_SRC-1:0] req_en;
  logic [NUM_SRC-1:0] grant;
  logic [IDX_W-1:0]   win_idx;
  logic               any_req;
  logic               tbl_sel;
  logic [ADDR_W-1:0]  tbl_base;

  // line 0 bypasses the global enable
  assign req_en = req_i & {{(NUM_SRC-1){gie_i}}, 1'b1};

  irq_prio_arb #(.NUM_SRC(NUM_SRC)) u_arb (
    .req_i   (req_en),
    .grant_o (grant),
    .idx_o   (win_idx),
    .any_o   (any_req)
  );

  irq_vec_guard #(.GUARD_CYCLES(GUARD_CYCLES)) u_guard (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .sel_o   (tbl_sel)
  );

  assign tbl_base = tbl_sel ? boot_base_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_addr_o  <= '0;
      vec_valid_o <= 1'b0;
      ack_o       <= '0;
    end else begin
      vec_valid_o <= any_req;
      ack_o       <= grant;
      if (any_req) vec_addr_o <= tbl_base + (ADDR_W'(win_idx) << 1);
    end
  end

  p_ack_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ack_o));

  p_valid_ack_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o == (ack_o != '0));

  p_reset_first_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i[0] |=> ack_o[0]);

  p_mask_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gie_i |=> (ack_o[NUM_SRC-1:1] == '0));

  p_zero_base_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tbl_sel && any_req) |=> (vec_addr_o < ADDR_W'(2 * NUM_SRC)) && !vec_addr_o[0]);
endmodule

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;
  localparam int NSRC = 8;
  localparam int AW   = 16;
  localparam logic [AW-1:0] BOOT = 16'h3C00;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] req = '0;
  logic            gie = 1'b0;
  logic            we = 1'b0;
  logic [1:0]      wdata = '0;
  logic [AW-1:0]   vaddr;
  logic            vvalid;
  logic [NSRC-1:0] ack;

  int total = 0;
  int bad   = 0;
  bit exp_sel = 1'b0;

  always #4 clk = ~clk;

  irq_vector_ctrl #(.NUM_SRC(NSRC), .ADDR_W(AW), .GUARD_CYCLES(4)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .gie_i(gie),
    .cfg_we_i(we), .cfg_wdata_i(wdata), .boot_base_i(BOOT),
    .vec_addr_o(vaddr), .vec_valid_o(vvalid), .ack_o(ack)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // drive req/gie, check one cycle later, then clear request
  task automatic fire(input string tag, input logic [NSRC-1:0] r, input logic g, input int win);
    @(negedge clk); req = r; gie = g;
    @(negedge clk);
    if (win < 0) begin
      chk({tag, " R9 valid"}, 32'(vvalid), 0);
      chk({tag, " R9 ack"}, 32'(ack), 0);
    end else begin
      chk({tag, " R4 valid"}, 32'(vvalid), 1);
      chk({tag, " R9 ack"}, 32'(ack), 32'(1 << win));
      chk({tag, " R4 addr"}, 32'(vaddr), 32'((exp_sel ? BOOT : 16'h0) + 2 * win));
    end
    req = '0;
    @(negedge clk);
    chk({tag, " R9 idle"}, 32'(vvalid), 0);
  endtask

  // unlock, then select write landing on edge 'dly' after the unlock edge
  task automatic guarded(input bit val, input int dly);
    @(negedge clk); we = 1'b1; wdata = 2'b10;
    @(negedge clk); we = 1'b0;
    repeat (dly - 1) @(negedge clk);
    we = 1'b1; wdata = {1'b0, val};
    @(negedge clk); we = 1'b0; wdata = '0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 valid", 32'(vvalid), 0);
    chk("R1 ack", 32'(ack), 0);
    chk("R1 addr", 32'(vaddr), 0);
  endtask

  task automatic t_single();
    for (int i = 0; i < NSRC; i++) fire("R5 single", NSRC'(1 << i), 1'b1, i);
  endtask

  task automatic t_priority();
    fire("R2 all", '1, 1'b1, 0);
    fire("R2 ext", 8'b1010_0110, 1'b1, 1);
    fire("R2 mid", 8'b1001_0000, 1'b1, 4);
    fire("R9 none", '0, 1'b1, -1);
  endtask

  task automatic t_mask();
    fire("R3 masked", 8'b1111_1110, 1'b0, -1);
    fire("R3 reset nomask", 8'b0000_1001, 1'b0, 0);
  endtask

  task automatic t_guard();
    @(negedge clk); we = 1'b1; wdata = 2'b01;   // no unlock
    @(negedge clk); we = 1'b0; wdata = '0;
    fire("R8 nounlock", 8'b0000_0100, 1'b1, 2);
    @(negedge clk); we = 1'b1; wdata = 2'b11;   // unlock alone does not select
    @(negedge clk); we = 1'b0; wdata = '0;
    fire("R7 unlock only", 8'b0000_0100, 1'b1, 2);
    guarded(1'b1, 5);                            // too late
    fire("R8 late", 8'b0000_1000, 1'b1, 3);
    guarded(1'b1, 4); exp_sel = 1'b1;            // last legal edge
    fire("R6 boot", 8'b0000_1000, 1'b1, 3);
    fire("R6 boot rst", 8'b0000_0001, 1'b0, 0);
    fire("R6 boot top", 8'b1000_0000, 1'b1, 7);
    @(negedge clk); we = 1'b1; wdata = 2'b00;   // unguarded clear ignored
    @(negedge clk); we = 1'b0;
    fire("R8 clear ignored", 8'b0000_0010, 1'b1, 1);
    guarded(1'b0, 1); exp_sel = 1'b0;
    fire("R5 back", 8'b0000_0010, 1'b1, 1);
  endtask

  initial begin
    #(8 * 100000);
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single();
    t_priority();
    t_mask();
    t_guard();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule